// File: doc/BRIEF.md
# 4B/5B Nibble Codec with Stream Delimiters

This block sits between a media-independent nibble interface and the 5-bit code-group path of a 100 Mb/s physical coding sublayer. On the transmit side it takes one nibble per clock, together with an enable and an error flag. Each packet opens with a start-delimiter pair placed on its first two nibbles and closes with an end-delimiter pair. The data nibbles in between become 4B/5B data groups. When the enable is low the block sends the idle group.

On the receive side it takes one aligned 5-bit group per clock. It waits in idle until a start-delimiter pair arrives, then decodes the data groups and raises the data-valid output for them. The packet ends on the end delimiter. Code violations inside a packet are reported through the error output together with a fixed error nibble, picked by a configuration input. A badly formed start of stream is reported as false carrier. A packet that breaks off into idle without an end delimiter is flagged as a premature end. Scrambling, symbol alignment and line coding belong to other blocks.

Top module: `pcs_nibble_codec`

## Requirements
- R1: While reset is asserted, tx_group_o is the idle group 11111, and rx_dv_o, rx_er_o and rxd_o are all 0.
- R2: While no packet is in progress and tx_en_i is low, tx_group_o is 11111 on every cycle, and tx_er_i has no effect.
- R3: Each transmit nibble appears as a group on tx_group_o one clock later. The first two nibbles with tx_en_i high are sent as 11000 and then 10001, whatever their value. Later nibbles 0 to F are sent as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: During the data part of a packet, a nibble that has both tx_en_i and tx_er_i high is sent as 00100 in place of its data.
- R5: The first nibble with tx_en_i low after a packet is sent as 01101 and the next as 00111, and idle follows. The enable must stay low for those two nibbles.
- R6: Each received group drives rx_dv_o, rx_er_o and rxd_o one clock later. For the pair 11000 then 10001 coming from idle, rx_dv_o stays 0. Each following data group from the R3 table gives rx_dv_o=1, rx_er_o=0 and its nibble on rxd_o.
- R7: A received 01101 inside a packet drives rx_dv_o to 0 for that group and for the group after it.
- R8: Inside a packet, any group that is not a data group or 01101 (for example 00000, 00011 or 00100) gives rx_dv_o=1 and rx_er_o=1. rxd_o then shows 0110 when err_sel_i is 0 and 0101 when err_sel_i is 1.
- R9: False carrier is a group outside a packet that is neither 11111 nor 11000, or a 11000 that is not followed by 10001. It gives rx_dv_o=0, rx_er_o=1 and rxd_o=1110, and this lasts until a 11111 group brings the outputs back to all zero.
- R10: Inside a packet, a single 11111 is reported as in R8. A second consecutive 11111 is also reported as in R8 and ends the packet, so the next idle group gives rx_dv_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Nibble/group clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| tx_er_i | input | 1 | Transmit error request |
| txd_i | input | 4 | Transmit nibble |
| tx_group_o | output | 5 | Transmit code group |
| rx_group_i | input | 5 | Aligned received code group |
| err_sel_i | input | 1 | Selects the code-error nibble (0: 0110, 1: 0101) |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| rxd_o | output | 4 | Receive nibble |

## Verification
Both directions register their outputs exactly once. A transmit nibble therefore shows up on tx_group_o one clock after the edge that samples it, and a received group shows up on the receive outputs one clock after its own edge. The bench drives each input on a falling edge and checks the result on the next falling edge. In that way each check lines up with the one edge that consumed the stimulus, and the state each group leaves behind is seen through the output of the following group. Delimiter, false-carrier and premature-end sequences are walked one group at a time, and every intermediate output is checked.

// File: rtl/pcs_codec_pkg.sv
package pcs_codec_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;
  localparam int NUM_DATA = 1 << NIB_W;

  typedef logic [GRP_W-1:0] grp_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam grp_t C_IDLE = 5'b11111;
  localparam grp_t C_SSD1 = 5'b11000;
  localparam grp_t C_SSD2 = 5'b10001;
  localparam grp_t C_ESD1 = 5'b01101;
  localparam grp_t C_ESD2 = 5'b00111;
  localparam grp_t C_HALT = 5'b00100;

  localparam nib_t FC_NIB   = 4'b1110;
  localparam nib_t CERR_A   = 4'b0110;
  localparam nib_t CERR_B   = 4'b0101;

  typedef enum logic [1:0] {TX_IDLE, TX_SSD2, TX_DATA, TX_ESD2} tx_st_e;
  typedef enum logic [2:0] {RX_IDLE, RX_GOTJ, RX_DATA, RX_DATA_I, RX_GOTT, RX_BAD} rx_st_e;

  typedef struct packed {
    logic hit;
    nib_t nib;
  } dec_t;

  function automatic grp_t enc_nib(input nib_t n);
    case (n)
      4'h0: enc_nib = 5'b11110;
      4'h1: enc_nib = 5'b01001;
      4'h2: enc_nib = 5'b10100;
      4'h3: enc_nib = 5'b10101;
      4'h4: enc_nib = 5'b01010;
      4'h5: enc_nib = 5'b01011;
      4'h6: enc_nib = 5'b01110;
      4'h7: enc_nib = 5'b01111;
      4'h8: enc_nib = 5'b10010;
      4'h9: enc_nib = 5'b10011;
      4'hA: enc_nib = 5'b10110;
      4'hB: enc_nib = 5'b10111;
      4'hC: enc_nib = 5'b11010;
      4'hD: enc_nib = 5'b11011;
      4'hE: enc_nib = 5'b11100;
      default: enc_nib = 5'b11101;
    endcase
  endfunction

  // inverse search over the data table
  function automatic dec_t dec_grp(input grp_t g);
    dec_t r;
    r = '0;
    for (int i = 0; i < NUM_DATA; i++) begin
      if (enc_nib(nib_t'(i)) == g) begin
        r.hit = 1'b1;
        r.nib = nib_t'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pcs_tx_enc.sv
module pcs_tx_enc
  import pcs_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic [GRP_W-1:0] tx_group_o
);
  tx_st_e st_q, st_d;
  grp_t   grp_q, grp_d;

  always_comb begin
    st_d  = st_q;
    grp_d = C_IDLE;
    case (st_q)
      TX_IDLE: if (tx_en_i) begin
        grp_d = C_SSD1;
        st_d  = TX_SSD2;
      end
      TX_SSD2: begin
        grp_d = C_SSD2;
        st_d  = TX_DATA;
      end
      TX_DATA: begin
        if (!tx_en_i) begin
          grp_d = C_ESD1;
          st_d  = TX_ESD2;
        end else if (tx_er_i) begin
          grp_d = C_HALT;
        end else begin
          grp_d = enc_nib(txd_i);
        end
      end
      default: begin
        grp_d = C_ESD2;
        st_d  = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      grp_q <= C_IDLE;
    end else begin
      st_q  <= st_d;
      grp_q <= grp_d;
    end
  end

  assign tx_group_o = grp_q;

  // R3
  ssd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_group_o == C_SSD1) |=> (tx_group_o == C_SSD2));
  // R5
  esd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_group_o == C_ESD1) |=> (tx_group_o == C_ESD2));
  // R4
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_group_o == C_HALT) |-> $past(tx_en_i && tx_er_i));
endmodule

// File: rtl/pcs_rx_dec.sv
module pcs_rx_dec
  import pcs_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] rx_group_i,
  input  logic             err_sel_i,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  rx_st_e st_q, st_d;
  logic   dv_q, dv_d, er_q, er_d;
  nib_t   rxd_q, rxd_d;
  nib_t   err_nib;
  dec_t   dec;

  assign err_nib = err_sel_i ? CERR_B : CERR_A;
  assign dec     = dec_grp(rx_group_i);

  always_comb begin
    st_d  = st_q;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    rxd_d = '0;
    case (st_q)
      RX_IDLE: begin
        if (rx_group_i == C_SSD1) begin
          st_d = RX_GOTJ;
        end else if (rx_group_i != C_IDLE) begin
          er_d  = 1'b1;
          rxd_d = FC_NIB;
          st_d  = RX_BAD;
        end
      end
      RX_GOTJ: begin
        if (rx_group_i == C_SSD2) begin
          st_d = RX_DATA;
        end else begin
          er_d  = 1'b1;
          rxd_d = FC_NIB;
          st_d  = (rx_group_i == C_IDLE) ? RX_IDLE : RX_BAD;
        end
      end
      RX_BAD: begin
        if (rx_group_i == C_IDLE) begin
          st_d = RX_IDLE;
        end else begin
          er_d  = 1'b1;
          rxd_d = FC_NIB;
        end
      end
      RX_DATA, RX_DATA_I: begin
        if (rx_group_i == C_ESD1) begin
          st_d = RX_GOTT;
        end else if (rx_group_i == C_IDLE) begin
          dv_d  = 1'b1;
          er_d  = 1'b1;
          rxd_d = err_nib;
          st_d  = (st_q == RX_DATA_I) ? RX_IDLE : RX_DATA_I;
        end else if (dec.hit) begin
          dv_d  = 1'b1;
          rxd_d = dec.nib;
          st_d  = RX_DATA;
        end else begin
          dv_d  = 1'b1;
          er_d  = 1'b1;
          rxd_d = err_nib;
          st_d  = RX_DATA;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      rxd_q <= '0;
    end else begin
      st_q  <= st_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      rxd_q <= rxd_d;
    end
  end

  assign rx_dv_o = dv_q;
  assign rx_er_o = er_q;
  assign rxd_o   = rxd_q;

  // R6
  dv_after_ssd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> ($past(st_q) == RX_DATA));
  // R7
  dv_end_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_dv_o) |-> ($past(rx_group_i) == C_ESD1 || $past(rx_group_i) == C_IDLE));
  // R8
  cerr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && rx_er_o) |-> (rxd_o == CERR_A || rxd_o == CERR_B));
endmodule

// File: rtl/pcs_nibble_codec.sv
module pcs_nibble_codec
  import pcs_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic [GRP_W-1:0] tx_group_o,
  input  logic [GRP_W-1:0] rx_group_i,
  input  logic             err_sel_i,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  pcs_tx_enc u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .tx_er_i    (tx_er_i),
    .txd_i      (txd_i),
    .tx_group_o (tx_group_o)
  );

  pcs_rx_dec u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_group_i (rx_group_i),
    .err_sel_i  (err_sel_i),
    .rx_dv_o    (rx_dv_o),
    .rx_er_o    (rx_er_o),
    .rxd_o      (rxd_o)
  );
endmodule

// File: tb/pcs_nibble_codec_tb.sv
module pcs_nibble_codec_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, tx_er;
  logic [3:0] txd;
  logic [4:0] tx_group;
  logic [4:0] rx_group;
  logic       err_sel;
  logic       rx_dv, rx_er;
  logic [3:0] rxd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [4:0] G_I = 5'b11111, G_J = 5'b11000, G_K = 5'b10001;
  localparam logic [4:0] G_T = 5'b01101, G_R = 5'b00111, G_H = 5'b00100;

  logic [4:0] tbl [16];
  initial begin
    tbl[0]  = 5'b11110; tbl[1]  = 5'b01001; tbl[2]  = 5'b10100; tbl[3]  = 5'b10101;
    tbl[4]  = 5'b01010; tbl[5]  = 5'b01011; tbl[6]  = 5'b01110; tbl[7]  = 5'b01111;
    tbl[8]  = 5'b10010; tbl[9]  = 5'b10011; tbl[10] = 5'b10110; tbl[11] = 5'b10111;
    tbl[12] = 5'b11010; tbl[13] = 5'b11011; tbl[14] = 5'b11100; tbl[15] = 5'b11101;
  end

  always #4 clk = ~clk;

  pcs_nibble_codec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .tx_er_i(tx_er), .txd_i(txd),
    .tx_group_o(tx_group), .rx_group_i(rx_group), .err_sel_i(err_sel),
    .rx_dv_o(rx_dv), .rx_er_o(rx_er), .rxd_o(rxd)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tx_step(logic en, logic er, logic [3:0] d, logic [4:0] exp, string tag);
    tx_en = en; tx_er = er; txd = d;
    @(negedge clk);
    chk(tag, int'(tx_group), int'(exp));
  endtask

  task automatic rx_step(logic [4:0] g, logic dv, logic er, logic [3:0] d, string tag);
    rx_group = g;
    @(negedge clk);
    chk({tag, " dv"}, int'(rx_dv), int'(dv));
    chk({tag, " er"}, int'(rx_er), int'(er));
    chk({tag, " rxd"}, int'(rxd), int'(d));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en = 0; tx_er = 0; txd = 0; rx_group = G_I; err_sel = 0;
    #20;
    chk("R1 tx_group", int'(tx_group), int'(G_I));
    chk("R1 rx_dv", int'(rx_dv), 0);
    chk("R1 rx_er", int'(rx_er), 0);
    chk("R1 rxd", int'(rxd), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_tx_idle();
    tx_step(0, 0, 4'h3, G_I, "R2 idle");
    tx_step(0, 1, 4'hA, G_I, "R2 er ignored");
    tx_step(0, 0, 4'h0, G_I, "R2 idle");
  endtask

  task automatic t_tx_frame();
    tx_step(1, 0, 4'h5, G_J, "R3 ssd1");
    tx_step(1, 0, 4'h5, G_K, "R3 ssd2");
    for (int i = 0; i < 16; i++) tx_step(1, 0, 4'(i), tbl[i], "R3 data");
    tx_step(0, 0, 4'h0, G_T, "R5 esd1");
    tx_step(0, 0, 4'h0, G_R, "R5 esd2");
    tx_step(0, 0, 4'h0, G_I, "R5 idle after");
  endtask

  task automatic t_tx_halt();
    tx_step(1, 1, 4'h5, G_J, "R3 ssd1 with er");
    tx_step(1, 0, 4'h5, G_K, "R3 ssd2");
    tx_step(1, 0, 4'h3, tbl[3], "R3 data");
    tx_step(1, 1, 4'h3, G_H, "R4 halt");
    tx_step(1, 0, 4'h7, tbl[7], "R4 after halt");
    tx_step(0, 0, 4'h0, G_T, "R5 esd1");
    tx_step(0, 0, 4'h0, G_R, "R5 esd2");
    tx_step(0, 0, 4'h0, G_I, "R2 idle");
  endtask

  task automatic t_rx_packet();
    err_sel = 0;
    rx_step(G_I, 0, 0, 0, "R6 idle");
    rx_step(G_J, 0, 0, 0, "R6 ssd1");
    rx_step(G_K, 0, 0, 0, "R6 ssd2");
    for (int i = 0; i < 16; i++) rx_step(tbl[i], 1, 0, 4'(i), "R6 data");
    rx_step(G_T, 0, 0, 0, "R7 esd1");
    rx_step(G_R, 0, 0, 0, "R7 esd2");
    rx_step(G_I, 0, 0, 0, "R7 idle");
  endtask

  task automatic t_rx_viol(logic sel);
    logic [3:0] e;
    e = sel ? 4'b0101 : 4'b0110;
    err_sel = sel;
    rx_step(G_J, 0, 0, 0, "R8 ssd1");
    rx_step(G_K, 0, 0, 0, "R8 ssd2");
    rx_step(tbl[3], 1, 0, 4'h3, "R8 data");
    rx_step(5'b00000, 1, 1, e, "R8 v00000");
    rx_step(5'b00011, 1, 1, e, "R8 v00011");
    rx_step(G_H, 1, 1, e, "R8 halt");
    rx_step(tbl[10], 1, 0, 4'hA, "R8 recover");
    rx_step(G_T, 0, 0, 0, "R7 esd1");
    rx_step(G_R, 0, 0, 0, "R7 esd2");
    rx_step(G_I, 0, 0, 0, "R7 idle");
    err_sel = 0;
  endtask

  task automatic t_rx_false();
    rx_step(tbl[6], 0, 1, 4'hE, "R9 stray");
    rx_step(5'b10101, 0, 1, 4'hE, "R9 held");
    rx_step(G_I, 0, 0, 0, "R9 clear");
    rx_step(G_J, 0, 0, 0, "R9 ssd1");
    rx_step(tbl[5], 0, 1, 4'hE, "R9 bad ssd2");
    rx_step(G_I, 0, 0, 0, "R9 clear");
  endtask

  task automatic t_rx_premature();
    rx_step(G_J, 0, 0, 0, "R10 ssd1");
    rx_step(G_K, 0, 0, 0, "R10 ssd2");
    rx_step(tbl[1], 1, 0, 4'h1, "R10 data");
    rx_step(G_I, 1, 1, 4'b0110, "R10 single idle");
    rx_step(tbl[2], 1, 0, 4'h2, "R10 resume");
    rx_step(G_I, 1, 1, 4'b0110, "R10 idle 1");
    rx_step(G_I, 1, 1, 4'b0110, "R10 idle 2");
    rx_step(G_I, 0, 0, 0, "R10 ended");
    rx_step(G_I, 0, 0, 0, "R10 stays idle");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_idle();
    t_tx_frame();
    t_tx_halt();
    t_rx_packet();
    t_rx_viol(1'b0);
    t_rx_viol(1'b1);
    t_rx_false();
    t_rx_premature();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule